// File: doc/BRIEF.md
# Interrupt entry sequencer

This block sits beside the execute stage of a small 8-bit microcontroller core. It decides when the core takes a reset request or a pending hardware interrupt, and then runs the entry sequence. While idle it looks at the pending-source vector, the global interrupt enable and a flag that says a conditional skip of the next instruction is still outstanding. When it accepts an entry it captures the current program counter and stack pointer. It then writes the return address onto the byte-wide stack in data memory, one byte per accepted transfer. After that it presents the target program counter from the vector table together with the updated stack pointer.

The write port toward data memory uses valid/ready. `mem_wr_valid` rises in the cycle after acceptance. The address and data stay stable while `mem_wr_valid` is high and `mem_wr_ready` is low. A byte counts as written only on a clock edge where both signals are high, so memory may stall the sequence for any number of cycles. The core-side outputs are plain pulses. When `entry_done` is high, the core loads `new_pc` and `new_sp` and clears its global enable, and the pending logic clears the bits shown on `pend_clear`.

Top module: `irq_entry_seq`

## Requirements
- R1: While `skip_pending` is high, no entry starts: an idle sequencer stays idle, `busy` stays low and no write is issued.
- R2: Neither a reset request nor a hardware interrupt is accepted while `gie` is low. Nothing is accepted when no request is present.
- R3: A reset request is examined before any pending source and always uses vector 0. Its `entry_done` carries `reset_ack` = 1, `new_pc` = 0 and `pend_clear` = 0.
- R4: Among pending sources the lowest set bit of `irq_pend` wins, and its vector number is that bit index plus one. At `entry_done`, `pend_clear` is the one-hot mask of that bit alone.
- R5: `new_pc` equals the vector number shifted left by one when `cfg_long_vec` = 1 (two-word slots), and equals the vector number itself when `cfg_long_vec` = 0.
- R6: The number of bytes pushed is set by `cfg_pc_width`: 2'b11 pushes 3 bytes, 2'b10 pushes 2 bytes, and 2'b00 or 2'b01 push 1 byte.
- R7: Byte k of the return address (k = 0 is the least significant) is written to address SP−k, where SP is the captured stack pointer. At `entry_done`, `new_sp` = SP − (number of bytes), modulo 2^SP_W.
- R8: While `mem_wr_valid` is high and `mem_wr_ready` is low, `mem_wr_addr` and `mem_wr_data` hold their values and the sequence does not advance.
- R9: `mem_wr_valid` first rises in the cycle after acceptance. `entry_done` is high for exactly one cycle, the cycle after the last accepted write, and the sequencer is idle again in the cycle after that.
- R10: `irq_req` is high whenever any bit of `irq_pend` is set.
- R11: Requests, enable, skip flag, PC, SP and straps are sampled only at acceptance. Changes to them during a sequence do not alter its writes, `new_pc`, `new_sp`, `pend_clear` or `reset_ack`.
- R12: Synchronous active-high `rst` returns the sequencer to idle. In the following cycle `busy`, `mem_wr_valid` and `entry_done` are low, even when `rst` arrives in the middle of a sequence.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_pend | input | NUM_SRC | Pending hardware sources, bit 0 highest priority |
| rst_req | input | 1 | Reset request (vector 0) |
| gie | input | 1 | Global interrupt enable |
| skip_pending | input | 1 | Next instruction is to be skipped; blocks entry |
| cur_pc | input | PC_W | Current word program counter (return address) |
| cur_sp | input | SP_W | Current stack pointer |
| cfg_long_vec | input | 1 | Strap: two-word vector slots |
| cfg_pc_width | input | 2 | Strap: pushed return address size |
| irq_req | output | 1 | Any source pending |
| busy | output | 1 | Entry sequence in progress |
| mem_wr_valid | output | 1 | Stack write offered |
| mem_wr_ready | input | 1 | Memory accepts the offered write |
| mem_wr_addr | output | SP_W | Stack write address |
| mem_wr_data | output | 8 | Stack write byte |
| entry_done | output | 1 | One-cycle pulse: load PC/SP, clear global enable |
| new_pc | output | PC_W | Vector table target, valid with `entry_done` |
| new_sp | output | SP_W | Stack pointer after the push, valid with `entry_done` |
| pend_clear | output | NUM_SRC | Pending bit to clear, valid with `entry_done` |
| reset_ack | output | 1 | The entry just completed was a reset |

## Verification
Single-bit pending vectors at both ends of the range separate the index-plus-one vector mapping from an off-by-one. Multi-bit vectors separate lowest-bit priority from highest-bit priority. A reset request combined with pending bits shows that reset takes precedence and that no source bit is cleared. Each value of the width strap, crossed with both slot sizes and with stack pointers near zero, shows the byte count, the byte order, the address decrement and the wrap. Random ready patterns expose any advance or change of data during a stall. Random changes of requests, enable, PC and straps right after acceptance show that nothing is resampled mid-sequence.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_PUSH = 2'd1,
    SEQ_LOAD = 2'd2
  } seq_state_e;

  localparam int unsigned PUSH_MAX = 3;

  // Strap decode: 2'b11 -> three bytes, 2'b10 -> two bytes, else one byte.
  function automatic logic [1:0] push_len(input logic [1:0] width_sel);
    case (width_sel)
      2'b11:   push_len = 2'd3;
      2'b10:   push_len = 2'd2;
      default: push_len = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/irq_pick.sv
module irq_pick #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned IDX_W   = 4
) (
  input  logic [NUM_SRC-1:0] pend,
  output logic               any,
  output logic [NUM_SRC-1:0] onehot,
  output logic [IDX_W-1:0]   idx
);

  logic [NUM_SRC-1:0] below;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_chain
    if (g == 0) begin : g_first
      assign below[g] = 1'b0;
    end else begin : g_rest
      assign below[g] = below[g-1] | pend[g-1];
    end
    assign onehot[g] = pend[g] & ~below[g];
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (onehot[i]) idx = idx | IDX_W'(i);
    end
  end

  assign any = |pend;

endmodule

// File: rtl/irq_push.sv
module irq_push
  import irq_entry_pkg::*;
#(
  parameter int unsigned PC_W  = 22,
  parameter int unsigned SP_W  = 16,
  parameter int unsigned CNT_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [PC_W-1:0]  cur_pc,
  input  logic [SP_W-1:0]  cur_sp,
  input  logic [CNT_W-1:0] len,
  input  logic             fire,
  output logic [SP_W-1:0]  addr,
  output logic [7:0]       data,
  output logic             last
);

  localparam int unsigned EXT_W = PUSH_MAX * 8;

  logic [SP_W-1:0]  sp_q;
  logic [EXT_W-1:0] pc_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] len_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q  <= '0;
      pc_q  <= '0;
      cnt_q <= '0;
      len_q <= CNT_W'(1);
    end else if (load) begin
      sp_q  <= cur_sp;
      pc_q  <= EXT_W'(cur_pc);
      cnt_q <= '0;
      len_q <= len;
    end else if (fire) begin
      sp_q  <= sp_q - 1'b1;
      cnt_q <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    data = '0;
    for (int b = 0; b < PUSH_MAX; b++) begin
      if (cnt_q == CNT_W'(b)) data = pc_q[b*8 +: 8];
    end
  end

  assign addr = sp_q;
  assign last = (cnt_q == len_q - 1'b1);

endmodule

// File: rtl/irq_vec.sv
module irq_vec #(
  parameter int unsigned VEC_W = 5,
  parameter int unsigned PC_W  = 22
) (
  input  logic [VEC_W-1:0] vec,
  input  logic             long_slot,
  output logic [PC_W-1:0]  target
);

  always_comb begin
    if (long_slot) target = PC_W'({vec, 1'b0});
    else           target = PC_W'(vec);
  end

endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned PC_W    = 22,
  parameter int unsigned SP_W    = 16
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_pend,
  input  logic               rst_req,
  input  logic               gie,
  input  logic               skip_pending,
  input  logic [PC_W-1:0]    cur_pc,
  input  logic [SP_W-1:0]    cur_sp,
  input  logic               cfg_long_vec,
  input  logic [1:0]         cfg_pc_width,
  output logic               irq_req,
  output logic               busy,
  output logic               mem_wr_valid,
  input  logic               mem_wr_ready,
  output logic [SP_W-1:0]    mem_wr_addr,
  output logic [7:0]         mem_wr_data,
  output logic               entry_done,
  output logic [PC_W-1:0]    new_pc,
  output logic [SP_W-1:0]    new_sp,
  output logic [NUM_SRC-1:0] pend_clear,
  output logic               reset_ack
);

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
  localparam int unsigned VEC_W = $clog2(NUM_SRC + 1);
  localparam int unsigned CNT_W = 2;

  seq_state_e state_q, state_d;

  logic               src_any;
  logic [NUM_SRC-1:0] src_onehot;
  logic [IDX_W-1:0]   src_idx;
  logic               accept;
  logic               fire;
  logic               push_last;
  logic [VEC_W-1:0]   vec_q;
  logic [NUM_SRC-1:0] clr_q;
  logic               rst_kind_q;
  logic               long_q;

  irq_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
    .pend   (irq_pend),
    .any    (src_any),
    .onehot (src_onehot),
    .idx    (src_idx)
  );

  // Entry is considered only from idle, never across a pending skip.
  assign accept = (state_q == SEQ_IDLE) && !skip_pending && gie &&
                  (rst_req || src_any);
  assign fire   = mem_wr_valid && mem_wr_ready;

  irq_push #(.PC_W(PC_W), .SP_W(SP_W), .CNT_W(CNT_W)) u_push (
    .clk    (clk),
    .rst    (rst),
    .load   (accept),
    .cur_pc (cur_pc),
    .cur_sp (cur_sp),
    .len    (push_len(cfg_pc_width)),
    .fire   (fire),
    .addr   (mem_wr_addr),
    .data   (mem_wr_data),
    .last   (push_last)
  );

  irq_vec #(.VEC_W(VEC_W), .PC_W(PC_W)) u_vec (
    .vec       (vec_q),
    .long_slot (long_q),
    .target    (new_pc)
  );

  always_comb begin
    state_d = state_q;
    case (state_q)
      SEQ_IDLE: if (accept) state_d = SEQ_PUSH;
      SEQ_PUSH: if (fire && push_last) state_d = SEQ_LOAD;
      SEQ_LOAD: state_d = SEQ_IDLE;
      default:  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= SEQ_IDLE;
      vec_q      <= '0;
      clr_q      <= '0;
      rst_kind_q <= 1'b0;
      long_q     <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        long_q <= cfg_long_vec;
        if (rst_req) begin
          vec_q      <= '0;
          clr_q      <= '0;
          rst_kind_q <= 1'b1;
        end else begin
          vec_q      <= VEC_W'(src_idx) + 1'b1;
          clr_q      <= src_onehot;
          rst_kind_q <= 1'b0;
        end
      end
    end
  end

  assign irq_req      = src_any;
  assign busy         = (state_q != SEQ_IDLE);
  assign mem_wr_valid = (state_q == SEQ_PUSH);
  assign entry_done   = (state_q == SEQ_LOAD);
  assign new_sp       = mem_wr_addr;
  assign pend_clear   = entry_done ? clr_q : '0;
  assign reset_ack    = entry_done && rst_kind_q;

endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
  parameter int unsigned NUM_SRC = 16,
  parameter int unsigned PC_W    = 22,
  parameter int unsigned SP_W    = 16
) (
  input logic               clk,
  input logic               rst,
  input logic               gie,
  input logic               skip_pending,
  input logic               busy,
  input logic               mem_wr_valid,
  input logic               mem_wr_ready,
  input logic [SP_W-1:0]    mem_wr_addr,
  input logic [7:0]         mem_wr_data,
  input logic               entry_done,
  input logic [PC_W-1:0]    new_pc,
  input logic [NUM_SRC-1:0] pend_clear,
  input logic               reset_ack
);

  // R1
  a_r1_skip_blocks: assert property (@(posedge clk) disable iff (rst)
    (!busy && skip_pending) |=> !busy);

  // R2
  a_r2_gie_needed: assert property (@(posedge clk) disable iff (rst)
    (!busy && !gie) |=> !busy);

  // R3
  a_r3_reset_vector: assert property (@(posedge clk) disable iff (rst)
    reset_ack |-> (entry_done && new_pc == '0 && pend_clear == '0));

  // R4
  a_r4_single_clear: assert property (@(posedge clk) disable iff (rst)
    entry_done |-> $onehot0(pend_clear));

  // R7
  a_r7_sp_step: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && mem_wr_ready) |=>
      (mem_wr_addr == SP_W'($past(mem_wr_addr) - 1'b1)));

  // R8
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_wr_addr) && $stable(mem_wr_data)));

  // R9
  a_r9_one_pulse: assert property (@(posedge clk) disable iff (rst)
    entry_done |=> (!entry_done && !busy));

  a_r9_after_write: assert property (@(posedge clk) disable iff (rst)
    (mem_wr_valid && mem_wr_ready) |=> (entry_done || mem_wr_valid));

  // R12
  a_r12_reset_idle: assert property (@(posedge clk)
    rst |=> (!busy && !mem_wr_valid && !entry_done));

endmodule

bind irq_entry_seq irq_entry_chk #(
  .NUM_SRC(NUM_SRC), .PC_W(PC_W), .SP_W(SP_W)
) u_chk (.*);

// File: tb/irq_entry_seq_test.sv
module irq_entry_seq_test;

  localparam int NS = 16;
  localparam int PW = 22;
  localparam int SW = 16;

  logic          clk = 1'b0;
  logic          rst;
  logic [NS-1:0] irq_pend;
  logic          rst_req, gie, skip_pending;
  logic [PW-1:0] cur_pc;
  logic [SW-1:0] cur_sp;
  logic          cfg_long_vec;
  logic [1:0]    cfg_pc_width;
  logic          irq_req, busy, mem_wr_valid, mem_wr_ready;
  logic [SW-1:0] mem_wr_addr;
  logic [7:0]    mem_wr_data;
  logic          entry_done;
  logic [PW-1:0] new_pc;
  logic [SW-1:0] new_sp;
  logic [NS-1:0] pend_clear;
  logic          reset_ack;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  irq_entry_seq #(.NUM_SRC(NS), .PC_W(PW), .SP_W(SW)) uut (.*);

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [1:0] w);
    if (w == 2'b11) return 3;
    if (w == 2'b10) return 2;
    return 1;
  endfunction

  function automatic int lowest(input logic [NS-1:0] p);
    for (int i = 0; i < NS; i++) if (p[i]) return i;
    return -1;
  endfunction

  function automatic logic [PW-1:0] exp_target(input logic [NS-1:0] p, input bit rr,
                                               input bit lv);
    int v;
    v = rr ? 0 : lowest(p) + 1;
    return PW'(lv ? v * 2 : v);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [PW-1:0] pc, input int k);
    logic [23:0] e;
    e = 24'(pc);
    return e[k*8 +: 8];
  endfunction

  task automatic idle_inputs();
    irq_pend = '0; rst_req = 1'b0; gie = 1'b0; skip_pending = 1'b0;
    mem_wr_ready = 1'b1;
  endtask

  task automatic run_entry(input logic [NS-1:0] p, input bit rr, input bit g,
                           input bit sk, input logic [PW-1:0] pc,
                           input logic [SW-1:0] sp, input bit lv,
                           input logic [1:0] w, input int rdy_pct,
                           input bit scramble);
    int  n, k;
    bit  pd, fin, prev_stall;
    logic [SW-1:0] prev_addr;
    logic [7:0]    prev_data;
    @(negedge clk);
    irq_pend = p; rst_req = rr; gie = g; skip_pending = sk;
    cur_pc = pc; cur_sp = sp; cfg_long_vec = lv; cfg_pc_width = w;
    mem_wr_ready = ($urandom % 100) < rdy_pct;
    #1;
    chk(irq_req == (|p), "R10", "irq_req", irq_req, |p);
    if (sk || !g || (!rr && p == '0)) begin
      for (int c = 0; c < 3; c++) begin
        @(negedge clk);
        chk(!busy && !mem_wr_valid && !entry_done, sk ? "R1" : "R2",
            "blocked entry started", busy, 0);
      end
      idle_inputs();
      return;
    end
    n = exp_len(w); k = 0; pd = 0; fin = 0; prev_stall = 0;
    prev_addr = '0; prev_data = '0;
    for (int it = 0; it < 200; it++) begin
      @(negedge clk);
      if (it == 0 && scramble) begin
        // R11: inputs change right after acceptance
        irq_pend = NS'($urandom); gie = $urandom % 2; rst_req = $urandom % 2;
        cur_pc = PW'($urandom); cur_sp = SW'($urandom);
        cfg_long_vec = ~lv; cfg_pc_width = ~w; skip_pending = $urandom % 2;
      end
      if (pd) begin
        chk(entry_done && !mem_wr_valid, "R9", "done after last write", entry_done, 1);
        chk(new_pc == exp_target(p, rr, lv), "R5", "new_pc", new_pc, exp_target(p, rr, lv));
        chk(new_sp == SW'(sp - SW'(n)), "R7", "new_sp", new_sp, SW'(sp - SW'(n)));
        chk(reset_ack == rr, "R3", "reset_ack", reset_ack, rr);
        if (rr)
          chk(pend_clear == '0, "R3", "pend_clear on reset", pend_clear, 0);
        else
          chk(pend_clear == (NS'(1) << lowest(p)), "R4", "pend_clear", pend_clear,
              NS'(1) << lowest(p));
        chk(k == n, "R6", "bytes pushed", k, n);
        fin = 1;
        idle_inputs();
        break;
      end
      chk(mem_wr_valid && !entry_done, "R9", "write offered", mem_wr_valid, 1);
      chk(mem_wr_addr == SW'(sp - SW'(k)), "R7", "write addr", mem_wr_addr, SW'(sp - SW'(k)));
      chk(mem_wr_data == exp_byte(pc, k), "R7", "write byte", mem_wr_data, exp_byte(pc, k));
      if (prev_stall)
        chk(mem_wr_addr == prev_addr && mem_wr_data == prev_data, "R8", "stall hold",
            mem_wr_data, prev_data);
      prev_addr = mem_wr_addr; prev_data = mem_wr_data;
      mem_wr_ready = ($urandom % 100) < rdy_pct;
      prev_stall = !mem_wr_ready;
      if (mem_wr_ready) begin
        k++;
        if (k == n) pd = 1;
      end
    end
    if (!fin) chk(0, "R9", "sequence never finished", 0, 1);
    @(negedge clk);
    chk(!entry_done && !busy, "R9", "idle after pulse", busy, 0);
  endtask

  initial begin
    #2_000_000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    cur_pc = '0; cur_sp = '0; cfg_long_vec = 0; cfg_pc_width = 0;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk(!busy && !mem_wr_valid && !entry_done, "R12", "reset state", busy, 0);
    rst = 1'b0;

    // Directed corners
    run_entry(16'h0001, 0, 1, 0, 22'h12345, 16'h0100, 0, 2'b10, 100, 0);
    run_entry(16'h8000, 0, 1, 0, 22'h3ABCDE, 16'h0200, 1, 2'b11, 100, 0);
    run_entry(16'hA0E0, 0, 1, 0, 22'h00FF, 16'h0001, 1, 2'b11, 60, 0);
    run_entry(16'h0F00, 1, 1, 0, 22'h2A5A5, 16'h0000, 1, 2'b10, 100, 0);
    run_entry(16'h0000, 1, 1, 0, 22'h00077, 16'h0010, 0, 2'b01, 100, 0);
    run_entry(16'h0004, 0, 1, 1, 22'h0, 16'h0, 0, 2'b00, 100, 0);
    run_entry(16'h0000, 1, 0, 0, 22'h0, 16'h0, 0, 2'b00, 100, 0);
    run_entry(16'h0000, 0, 1, 0, 22'h0, 16'h0, 0, 2'b00, 100, 0);
    run_entry(16'h0300, 0, 1, 0, 22'h1F00F, 16'h0400, 0, 2'b00, 30, 1);

    // R12: reset in the middle of a sequence
    @(negedge clk);
    irq_pend = 16'h0010; gie = 1; cur_sp = 16'h0300; cfg_pc_width = 2'b11;
    mem_wr_ready = 1'b0;
    @(negedge clk);
    chk(mem_wr_valid, "R9", "write offered after accept", mem_wr_valid, 1);
    idle_inputs(); mem_wr_ready = 1'b0; rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !mem_wr_valid && !entry_done, "R12", "mid-sequence reset", busy, 0);

    // Random mix
    for (int t = 0; t < 60; t++) begin
      logic [NS-1:0] p;
      p = ($urandom % 4 == 0) ? NS'(1) << ($urandom % NS) : NS'($urandom);
      run_entry(p, ($urandom % 5) == 0, ($urandom % 8) != 0, ($urandom % 8) == 0,
                PW'($urandom), SW'($urandom % 8 == 0 ? $urandom % 3 : $urandom),
                $urandom % 2, 2'($urandom), 40 + ($urandom % 61), $urandom % 2);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule